// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM and drives the memory's command pins from reset until the device can be used. It holds clock-enable low while the clock settles. It then raises clock-enable with a no-operation and issues the bring-up commands in their required order. First comes an extended mode write that enables the DLL and picks the output drive strength. Next comes a mode write that resets the DLL, then a precharge of every bank. At least two auto-refreshes follow. The last command is the mode write that sets the operating burst length, burst ordering and CAS latency. Every wait is a parameter counted in clock cycles. On every cycle between required commands, the block drives a no-operation.

Once initialization is complete, `init_done` goes high and stays high. From then on, a refresh-interval counter raises `ref_due` when an auto-refresh is owed. The normal-traffic controller issues that refresh itself and reports it back on `ref_ack`, which restarts the interval. All pins are plain level signals with no handshake. The configuration inputs must be held stable from reset release until `init_done`.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and for at least STABLE_CYC cycles after reset is released, `ddr_cke` is low and the command pins carry a no-operation.
- R2: `ddr_cke` rises in a cycle whose command is a no-operation. At least one cycle with clock-enable high and a no-operation comes before the first real command. `ddr_cke` never falls again until the next reset.
- R3: The command order is fixed: extended mode write, DLL-reset mode write, precharge-all, INIT_REFS auto-refreshes (never fewer than two), final mode write. The extended mode write uses bank 01, A0 = 0, A1 = `cfg_half_drive`, and all other address bits 0.
- R4: The DLL-reset mode write uses bank 00 and A8 = 1. Its other address bits are equal to those of the final mode write.
- R5: Precharge-all is issued with A10 = 1.
- R6: The final mode write uses bank 00. It places the burst-length code on A2:A0, the ordering bit (1 = interleaved) on A3 and the latency code on A6:A4, and has A7..A12 all 0 (A8 cleared).
- R7: A latency code of 010 (2) or 110 (2.5) passes unchanged to A6:A4. Every other code is replaced by 110.
- R8: A burst-length code of 001, 010 or 011 (2, 4, 8) passes unchanged to A2:A0. Every other code is replaced by 010.
- R9: Command encoding on {cs_n, ras_n, cas_n, we_n}: no-operation 0111, mode write 0000, precharge 0010, refresh 0001. The next command comes at least T_MRD cycles after a mode write, T_RP cycles after the precharge and T_RFC cycles after a refresh. Every other cycle carries a no-operation.
- R10: `init_done` rises no earlier than T_MRD cycles after the final mode write, and no earlier than DLL_LOCK_CYC cycles after the DLL-reset write. Once high it stays high, and only no-operations follow.
- R11: `ref_due` is high only while `init_done` is high. It rises exactly REF_INT_CYC cycles after the most recent refresh, whether issued during init or reported on `ref_ack`. A cycle with `ref_ack` high drops `ref_due` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_code | input | 3 | Burst-length code for the mode word |
| cfg_interleave | input | 1 | 1 selects interleaved burst ordering |
| cfg_cas_code | input | 3 | CAS latency code for the mode word |
| cfg_half_drive | input | 1 | 1 selects half-strength output drive |
| ref_ack | input | 1 | Pulse: one auto-refresh was issued after init |
| ddr_cke | output | 1 | Clock enable to the memory |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank select |
| ddr_addr | output | AW | Address / mode word |
| init_done | output | 1 | Initialization complete |
| ref_due | output | 1 | Auto-refresh owed |

## Verification
The assertions check several rules on every cycle. Clock-enable never drops after rising, and it is never low while a real command is on the pins. A no-operation directly follows each mode write, precharge and refresh. Mode writes to bank 00 keep A7 and A9..A12 at zero. `init_done` is sticky, with only no-operations after it. A refresh acknowledge always clears `ref_due`. The bench's scenarios are needed for the rest, because those checks span many cycles or depend on the configuration: the full command order, the exact address words including the substitution of reserved codes, the minimum gaps between commands, the DLL lock wait before `init_done`, and the exact cycle on which `ref_due` rises.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } ddr_cmd_e;

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_WAKE,
    ST_EMRS,
    ST_W_EMRS,
    ST_DLLRST,
    ST_W_DLL,
    ST_PREA,
    ST_W_PRE,
    ST_REF,
    ST_W_REF,
    ST_MODE,
    ST_W_MODE,
    ST_LOCK,
    ST_DONE
  } init_st_e;

  function automatic logic [2:0] legal_cas(input logic [2:0] code);
    return (code == 3'b010 || code == 3'b110) ? code : 3'b110;
  endfunction

  function automatic logic [2:0] legal_burst(input logic [2:0] code);
    return (code == 3'b001 || code == 3'b010 || code == 3'b011) ? code : 3'b010;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_wait_timer.sv
module ddr_wait_timer #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= RST_VAL;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R9: an expired wait stays expired until reloaded
  a_r9_wait_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
endmodule

// File: rtl/ddr_mode_fmt.sv
module ddr_mode_fmt #(
  parameter int AW = 13
) (
  input  logic [2:0]    burst_code,
  input  logic          interleave,
  input  logic [2:0]    cas_code,
  input  logic          half_drive,
  output logic [AW-1:0] mode_word,
  output logic [AW-1:0] ext_word
);
  import ddr_init_pkg::*;

  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = legal_burst(burst_code);
    mode_word[3]   = interleave;
    mode_word[6:4] = legal_cas(cas_code);
    ext_word       = '0;
    ext_word[0]    = 1'b0;        // DLL enabled
    ext_word[1]    = half_drive;
  end
endmodule

// File: rtl/ddr_refresh_timer.sv
module ddr_refresh_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic armed,
  output logic due
);
  localparam int IV = (INTERVAL < 1) ? 1 : INTERVAL;
  localparam int CW = $clog2(IV + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (restart)     cnt_q <= CW'(IV);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign due = armed && (cnt_q == '0);

  // R11: a refresh clears the request on the following cycle
  a_r11_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !due);
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int AW           = 13,
  parameter int BA_W         = 2,
  parameter int STABLE_CYC   = 40000,
  parameter int T_MRD        = 2,
  parameter int T_RP         = 4,
  parameter int T_RFC        = 15,
  parameter int DLL_LOCK_CYC = 200,
  parameter int REF_INT_CYC  = 1560,
  parameter int INIT_REFS    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cfg_burst_code,
  input  logic            cfg_interleave,
  input  logic [2:0]      cfg_cas_code,
  input  logic            cfg_half_drive,
  input  logic            ref_ack,
  output logic            ddr_cke,
  output logic            ddr_cs_n,
  output logic            ddr_ras_n,
  output logic            ddr_cas_n,
  output logic            ddr_we_n,
  output logic [BA_W-1:0] ddr_ba,
  output logic [AW-1:0]   ddr_addr,
  output logic            init_done,
  output logic            ref_due
);
  import ddr_init_pkg::*;

  localparam int GAP_MRD = imax(T_MRD, 2);
  localparam int GAP_RP  = imax(T_RP, 2);
  localparam int GAP_RFC = imax(T_RFC, 2);
  localparam int HOLD_N  = imax(STABLE_CYC, 1);
  localparam int NREF    = imax(INIT_REFS, 2);
  localparam int LOCK_N  = imax(DLL_LOCK_CYC, 1);
  localparam int WMAX    = imax(HOLD_N, imax(GAP_MRD, imax(GAP_RP, GAP_RFC)));
  localparam int WW      = $clog2(WMAX + 1);
  localparam int LW      = $clog2(LOCK_N + 1);
  localparam int RW      = $clog2(NREF + 1);

  init_st_e        st_q, st_d;
  logic            wt_load, wt_zero, lk_load, lk_zero;
  logic [WW-1:0]   wt_val;
  logic [RW-1:0]   ref_num_q;
  logic [AW-1:0]   mode_word, ext_word;
  ddr_cmd_e        cmd_q;
  logic            cke_q, done_q;
  logic [BA_W-1:0] ba_q;
  logic [AW-1:0]   addr_q;

  ddr_mode_fmt #(.AW(AW)) u_fmt (
    .burst_code (cfg_burst_code),
    .interleave (cfg_interleave),
    .cas_code   (cfg_cas_code),
    .half_drive (cfg_half_drive),
    .mode_word  (mode_word),
    .ext_word   (ext_word)
  );

  ddr_wait_timer #(.W(WW), .RST_VAL(WW'(HOLD_N - 1))) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wt_load),
    .load_val (wt_val),
    .zero     (wt_zero)
  );

  ddr_wait_timer #(.W(LW), .RST_VAL('0)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (lk_load),
    .load_val (LW'(LOCK_N)),
    .zero     (lk_zero)
  );

  ddr_refresh_timer #(.INTERVAL(REF_INT_CYC)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (st_q == ST_REF || ref_ack),
    .armed   (done_q),
    .due     (ref_due)
  );

  always_comb begin
    st_d    = st_q;
    wt_load = 1'b0;
    wt_val  = '0;
    lk_load = 1'b0;
    unique case (st_q)
      ST_HOLD:   if (wt_zero) st_d = ST_WAKE;
      ST_WAKE:   st_d = ST_EMRS;
      ST_EMRS:   begin wt_load = 1'b1; wt_val = WW'(GAP_MRD - 2); st_d = ST_W_EMRS; end
      ST_W_EMRS: if (wt_zero) st_d = ST_DLLRST;
      ST_DLLRST: begin
        wt_load = 1'b1; wt_val = WW'(GAP_MRD - 2); lk_load = 1'b1; st_d = ST_W_DLL;
      end
      ST_W_DLL:  if (wt_zero) st_d = ST_PREA;
      ST_PREA:   begin wt_load = 1'b1; wt_val = WW'(GAP_RP - 2); st_d = ST_W_PRE; end
      ST_W_PRE:  if (wt_zero) st_d = ST_REF;
      ST_REF:    begin wt_load = 1'b1; wt_val = WW'(GAP_RFC - 2); st_d = ST_W_REF; end
      ST_W_REF:  if (wt_zero) st_d = (ref_num_q == RW'(NREF)) ? ST_MODE : ST_REF;
      ST_MODE:   begin wt_load = 1'b1; wt_val = WW'(GAP_MRD - 2); st_d = ST_W_MODE; end
      ST_W_MODE: if (wt_zero) st_d = lk_zero ? ST_DONE : ST_LOCK;
      ST_LOCK:   if (lk_zero) st_d = ST_DONE;
      ST_DONE:   st_d = ST_DONE;
      default:   st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_HOLD;
      ref_num_q <= '0;
      done_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_DONE);
      if (st_q == ST_REF) ref_num_q <= ref_num_q + 1'b1;
    end
  end

  // Registered pin stage: pins show the command of the previous state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q  <= 1'b0;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      cke_q  <= cke_q || (st_q != ST_HOLD);
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      unique case (st_q)
        ST_EMRS:   begin cmd_q <= CMD_MRS; ba_q <= BA_W'(1); addr_q <= ext_word; end
        ST_DLLRST: begin cmd_q <= CMD_MRS; addr_q <= mode_word | (AW'(1) << 8); end
        ST_PREA:   begin cmd_q <= CMD_PRE; addr_q <= AW'(1) << 10; end
        ST_REF:    cmd_q <= CMD_REF;
        ST_MODE:   begin cmd_q <= CMD_MRS; addr_q <= mode_word; end
        default:   ;
      endcase
    end
  end

  assign ddr_cke = cke_q;
  assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = cmd_q;
  assign ddr_ba    = ba_q;
  assign ddr_addr  = addr_q;
  assign init_done = done_q;

  // R1: while clock-enable is low only no-operations appear
  a_r1_nop_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_cke |-> (cmd_q == CMD_NOP));
  // R2: clock-enable never drops once raised
  a_r2_cke_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_cke |=> ddr_cke);
  // R6: mode writes to bank 0 keep test and reserved bits clear
  a_r6_mode_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS && ba_q == '0) |-> (addr_q[7] == 1'b0 && addr_q[AW-1:9] == '0));
  // R9: every issued command is followed by a no-operation
  a_r9_nop_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP));
  // R10: done is sticky and the pins stay quiet afterwards
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  a_r10_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd_q == CMD_NOP));
endmodule

// File: tb/ddr_init_seq_tb_top.sv
`timescale 1ns/100ps
module ddr_init_seq_tb_top;
  localparam int STABLE = 40;
  localparam int TMRD   = 3;
  localparam int TRP    = 3;
  localparam int TRFC   = 8;
  localparam int LOCK   = 200;
  localparam int REFI   = 300;
  localparam int NREF   = 2;
  localparam logic [3:0] C_NOP = 4'b0111, C_MRS = 4'b0000, C_PRE = 4'b0010, C_REF = 4'b0001;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [2:0] cfg_burst_code = 3'b010, cfg_cas_code = 3'b010;
  logic cfg_interleave = 1'b0, cfg_half_drive = 1'b0, ref_ack = 1'b0;
  logic ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, init_done, ref_due;
  logic [1:0]  ddr_ba;
  logic [12:0] ddr_addr;

  ddr_init_seq #(.AW(13), .BA_W(2), .STABLE_CYC(STABLE), .T_MRD(TMRD), .T_RP(TRP),
    .T_RFC(TRFC), .DLL_LOCK_CYC(LOCK), .REF_INT_CYC(REFI), .INIT_REFS(NREF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_burst_code(cfg_burst_code), .cfg_interleave(cfg_interleave),
    .cfg_cas_code(cfg_cas_code), .cfg_half_drive(cfg_half_drive), .ref_ack(ref_ack),
    .ddr_cke(ddr_cke), .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n),
    .ddr_we_n(ddr_we_n), .ddr_ba(ddr_ba), .ddr_addr(ddr_addr), .init_done(init_done),
    .ref_due(ref_due));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_cl(input logic [2:0] c);
    return (c == 3'b010 || c == 3'b110) ? c : 3'b110;
  endfunction
  function automatic logic [2:0] exp_bl(input logic [2:0] c);
    return (c >= 3'b001 && c <= 3'b011) ? c : 3'b010;
  endfunction
  function automatic logic [12:0] exp_mode(input logic [2:0] bl, input logic il, input logic [2:0] cl);
    return {6'b0, exp_cl(cl), il, exp_bl(bl)};
  endfunction
  function automatic int min_gap(input logic [3:0] k);
    return (k == C_MRS) ? TMRD : (k == C_PRE) ? TRP : TRFC;
  endfunction

  task automatic run_one(input logic [2:0] bl, input logic il, input logic [2:0] cl, input logic hd);
    logic [3:0]  kind [16];
    logic [12:0] ad   [16];
    logic [1:0]  bb   [16];
    int          tt   [16];
    int n = 0, t = 0, cke_low = 0, cke_rise = -1, bad = 0, fell = 0, td, last, lref, trise, k;
    logic [3:0] c;
    logic [12:0] em;
    cfg_burst_code = bl; cfg_interleave = il; cfg_cas_code = cl; cfg_half_drive = hd;
    ref_ack = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ddr_cke == 1'b0 && init_done == 1'b0 && ref_due == 1'b0, "R1", "reset outputs",
        {ddr_cke, init_done, ref_due}, 0);
    chk({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == C_NOP, "R1", "reset command",
        {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, C_NOP);
    rst_n = 1'b1;
    while (!init_done && t < 5000) begin
      @(negedge clk);
      c = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
      if (!ddr_cke) begin
        if (cke_rise >= 0) fell++; else cke_low++;
        if (c != C_NOP) bad++;
      end else if (cke_rise < 0) begin
        cke_rise = t;
        if (c != C_NOP) bad++;
      end
      if (c == C_MRS || c == C_PRE || c == C_REF) begin
        if (n < 16) begin kind[n] = c; ad[n] = ddr_addr; bb[n] = ddr_ba; tt[n] = t; end
        n++;
      end else if (c != C_NOP) bad++;
      t++;
    end
    td = t - 1;
    chk(cke_low >= STABLE, "R1", "cke low cycles", cke_low, STABLE);
    chk(bad == 0, "R9", "non-NOP filler cycles", bad, 0);
    chk(fell == 0, "R2", "cke falls after rising", fell, 0);
    chk(init_done == 1'b1, "R10", "init_done reached", init_done, 1);
    chk(n == 4 + NREF, "R3", "command count", n, 4 + NREF);
    if (n != 4 + NREF) return;
    last = n - 1;
    chk(tt[0] - cke_rise >= 1, "R2", "NOP cycles with cke high before first command",
        tt[0] - cke_rise, 1);
    em = {11'b0, hd, 1'b0};
    chk(kind[0] == C_MRS && bb[0] == 2'b01 && ad[0] == em, "R3", "extended mode write",
        {kind[0], bb[0], ad[0]}, {C_MRS, 2'b01, em});
    chk(kind[1] == C_MRS && bb[1] == 2'b00 && ad[1] == (exp_mode(bl, il, cl) | 13'h100), "R4",
        "DLL reset write", ad[1], exp_mode(bl, il, cl) | 13'h100);
    chk(kind[2] == C_PRE && ad[2][10] == 1'b1, "R5", "precharge-all", {kind[2], ad[2]},
        {C_PRE, 13'h400});
    for (int i = 3; i < 3 + NREF; i++)
      chk(kind[i] == C_REF, "R3", "refresh in sequence", kind[i], C_REF);
    chk(kind[last] == C_MRS && bb[last] == 2'b00, "R6", "final mode write cmd/bank",
        {kind[last], bb[last]}, {C_MRS, 2'b00});
    chk(ad[last][6:4] == exp_cl(cl), "R7", "latency field", ad[last][6:4], exp_cl(cl));
    chk(ad[last][2:0] == exp_bl(bl), "R8", "burst field", ad[last][2:0], exp_bl(bl));
    chk(ad[last] == exp_mode(bl, il, cl), "R6", "final mode word", ad[last], exp_mode(bl, il, cl));
    for (int i = 1; i < n; i++)
      chk(tt[i] - tt[i-1] >= min_gap(kind[i-1]) && tt[i] - tt[i-1] <= min_gap(kind[i-1]) + 2,
          "R9", "command gap", tt[i] - tt[i-1], min_gap(kind[i-1]));
    chk(td - tt[last] >= TMRD, "R10", "done after final mode write", td - tt[last], TMRD);
    chk(td - tt[1] >= LOCK, "R10", "done after DLL lock wait", td - tt[1], LOCK);
    chk(td <= ((tt[last] + TMRD > tt[1] + LOCK) ? tt[last] + TMRD : tt[1] + LOCK) + 3, "R10",
        "done not stalled", td, tt[1] + LOCK);
    lref = tt[2 + NREF];
    trise = -1; bad = 0;
    while (trise < 0 && t < td + 3 * REFI) begin
      if (ref_due) trise = t - 1;
      else begin
        @(negedge clk);
        if ({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} != C_NOP || !init_done) bad++;
        t++;
      end
    end
    chk(bad == 0, "R10", "quiet and done after init", bad, 0);
    chk(trise == lref + REFI, "R11", "first refresh request cycle", trise, lref + REFI);
    ref_ack = 1'b1;
    @(negedge clk);
    ref_ack = 1'b0;
    chk(ref_due == 1'b0, "R11", "request cleared by ack", ref_due, 0);
    k = 0;
    while (!ref_due && k < 3 * REFI) begin @(negedge clk); k++; end
    chk(k == REFI, "R11", "request after ack", k, REFI);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 150000, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    run_one(3'b001, 1'b0, 3'b010, 1'b0);   // legal CL 2, BL 2
    run_one(3'b011, 1'b1, 3'b110, 1'b1);   // CL 2.5, BL 8, interleaved, half drive
    run_one(3'b000, 1'b0, 3'b000, 1'b0);   // reserved codes substituted (R7, R8)
    run_one(3'b111, 1'b1, 3'b111, 1'b1);
    for (int r = 0; r < 6; r++)
      run_one(3'($urandom_range(7)), 1'($urandom_range(1)), 3'($urandom_range(7)),
              1'($urandom_range(1)));
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule